// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block finds the one data dependence in a five-stage in-order pipeline that forwarding cannot cover. A load sitting in the execute stage produces its result only at the end of the memory stage. If the instruction now being decoded reads the register that the load will write, the value does not yet exist anywhere in the pipeline. The block checks for that case combinationally in every cycle. When it occurs, the block freezes the program counter and the fetch/decode register for one cycle. It also clears every control bit entering the decode/execute register, so that execute receives a harmless empty slot.

The instructions ahead of that slot keep moving through memory and writeback. On the next cycle the load has left execute and the condition clears by itself. The dependent instruction then meets the load value one stage later, where the forwarding network can supply it.

For verification, the block carries a small register harness: the program counter, the fetch/decode instruction register, the decode/execute control word and load destination, and the two control-word stages behind execute. The freeze and the inserted empty slot can therefore be seen at the ports.

Top module: `lu_stall_unit`

## Requirements
- R1: A stall is raised when bit 0 (memory read) of the decode/execute control word is 1 and the decode/execute destination equals the source field in bits [25:21] of the decoded instruction.
- R2: During a stall the program counter keeps its value; otherwise it advances by 4 on each clock.
- R3: During a stall the fetch/decode instruction register keeps its value; otherwise it loads the fetched word.
- R4: During a stall the control word written into decode/execute is all zero; otherwise it is a copy of the decoded control word.
- R5: The control words in the two stages after execute advance on every clock, stall or not.
- R6: A stall never lasts longer than one cycle; the cycle after a stall has no stall.
- R7: A load whose destination is register 0 never causes a stall.
- R8: A match between the destination and the second field, bits [20:16], of the decoded instruction causes a stall only when the uses-second-field input is 1.
- R9: No stall is raised when bit 0 of the decode/execute control word is 0, even if the register numbers match.
- R10: Reset clears the program counter, the instruction register and all control-word stages to zero, and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_instr | input | 32 | Instruction word read at the current program counter |
| dec_ctrl | input | 8 | Control word decoded from the instruction in decode; bit 0 is memory read |
| dec_uses_rt | input | 1 | Decoded instruction reads its second register field |
| pc_q | output | 32 | Program counter |
| ifid_instr_q | output | 32 | Instruction held in the fetch/decode register |
| idex_ctrl_q | output | 8 | Control word in the decode/execute register |
| idex_rt_q | output | 5 | Destination captured in decode/execute |
| exmem_ctrl_q | output | 8 | Control word in the execute/memory stage |
| memwb_ctrl_q | output | 8 | Control word in the memory/writeback stage |
| pc_write | output | 1 | Program counter update enable |
| ifid_write | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Zero the control word entering decode/execute |

## Verification
The hardest case to reach from the ports is two loads in a row where the second load depends on the first, and a store after them depends on the second. The empty slot inserted for the first stall must not suppress the second stall: after one frozen cycle, the second load reaches execute and must cause a fresh freeze. The stimulus is a fetched program, fed in order and decoded in the bench. It places loads with destinations that match, do not match, or are register 0 in front of consumers that read the first field, the second field, or neither. The chained-load case comes last, so that the earlier stalls have already shifted the fetch stream.

// File: rtl/lu_pkg.sv
package lu_pkg;
    localparam int unsigned RS_LSB    = 21;
    localparam int unsigned RT_LSB    = 16;
    localparam int unsigned MEMRD_BIT = 0;
endpackage

// File: rtl/lu_detect.sv
module lu_detect #(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_mem_read,
    input  logic [AW-1:0] ex_dst,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic          id_uses_b,
    output logic          hazard
);
    logic dst_live;
    logic hit_a;
    logic hit_b;

    always_comb begin
        dst_live = ex_mem_read && (ex_dst != '0);
        hit_a    = (ex_dst == id_src_a);
        hit_b    = id_uses_b && (ex_dst == id_src_b);
        hazard   = dst_live && (hit_a || hit_b);
    end

    assert_zero_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !hazard);
    assert_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_mem_read |-> !hazard);
endmodule

// File: rtl/lu_front.sv
module lu_front #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned PC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [INSTR_W-1:0] fetch_instr,
    output logic [PC_W-1:0]    pc_q,
    output logic [INSTR_W-1:0] instr_q
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    typedef struct packed {
        logic [PC_W-1:0]    pc;
        logic [INSTR_W-1:0] instr;
    } front_t;

    front_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            st_d.pc    = st_q.pc + STEP;
            st_d.instr = fetch_instr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_q    = st_q.pc;
    assign instr_q = st_q.instr;

    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q.pc));
    assert_ifid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q.instr));
endmodule

// File: rtl/lu_idex.sv
module lu_idex #(
    parameter int unsigned CTRL_W = 8,
    parameter int unsigned AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bubble,
    input  logic [CTRL_W-1:0] dec_ctrl,
    input  logic [AW-1:0]     dec_dst,
    output logic [CTRL_W-1:0] ex_ctrl_q,
    output logic [AW-1:0]     ex_dst_q,
    output logic [CTRL_W-1:0] mem_ctrl_q,
    output logic [CTRL_W-1:0] wb_ctrl_q
);
    typedef struct packed {
        logic [CTRL_W-1:0] ex_ctrl;
        logic [AW-1:0]     ex_dst;
        logic [CTRL_W-1:0] mem_ctrl;
        logic [CTRL_W-1:0] wb_ctrl;
    } back_t;

    back_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ex_ctrl  = bubble ? '0 : dec_ctrl;
        st_d.ex_dst   = dec_dst;
        st_d.mem_ctrl = st_q.ex_ctrl;
        st_d.wb_ctrl  = st_q.mem_ctrl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ex_ctrl_q  = st_q.ex_ctrl;
    assign ex_dst_q   = st_q.ex_dst;
    assign mem_ctrl_q = st_q.mem_ctrl;
    assign wb_ctrl_q  = st_q.wb_ctrl;

    assert_bubble_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (ex_ctrl_q == '0));
    assert_back_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (wb_ctrl_q == $past(mem_ctrl_q)));
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned AW      = 5,
    parameter int unsigned PC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] fetch_instr,
    input  logic [CTRL_W-1:0]  dec_ctrl,
    input  logic               dec_uses_rt,
    output logic [PC_W-1:0]    pc_q,
    output logic [INSTR_W-1:0] ifid_instr_q,
    output logic [CTRL_W-1:0]  idex_ctrl_q,
    output logic [AW-1:0]      idex_rt_q,
    output logic [CTRL_W-1:0]  exmem_ctrl_q,
    output logic [CTRL_W-1:0]  memwb_ctrl_q,
    output logic               pc_write,
    output logic               ifid_write,
    output logic               idex_bubble
);
    import lu_pkg::*;

    logic          stall;
    logic [AW-1:0] id_rs;
    logic [AW-1:0] id_rt;

    assign id_rs = ifid_instr_q[RS_LSB +: AW];
    assign id_rt = ifid_instr_q[RT_LSB +: AW];

    lu_detect #(.AW(AW)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .ex_mem_read (idex_ctrl_q[MEMRD_BIT]),
        .ex_dst      (idex_rt_q),
        .id_src_a    (id_rs),
        .id_src_b    (id_rt),
        .id_uses_b   (dec_uses_rt),
        .hazard      (stall)
    );

    lu_front #(.PC_W(PC_W), .INSTR_W(INSTR_W), .PC_STEP(PC_STEP)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (stall),
        .fetch_instr (fetch_instr),
        .pc_q        (pc_q),
        .instr_q     (ifid_instr_q)
    );

    lu_idex #(.CTRL_W(CTRL_W), .AW(AW)) u_idex (
        .clk        (clk),
        .rst_n      (rst_n),
        .bubble     (stall),
        .dec_ctrl   (dec_ctrl),
        .dec_dst    (id_rt),
        .ex_ctrl_q  (idex_ctrl_q),
        .ex_dst_q   (idex_rt_q),
        .mem_ctrl_q (exmem_ctrl_q),
        .wb_ctrl_q  (memwb_ctrl_q)
    );

    assign pc_write    = !stall;
    assign ifid_write  = !stall;
    assign idex_bubble = stall;

    assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> !idex_bubble);
    assert_rs_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_ctrl_q[MEMRD_BIT] && (idex_rt_q != '0) && (idex_rt_q == id_rs)) |-> !pc_write);
endmodule

// File: tb/tb_lu_stall_unit.sv
`timescale 1ns/1ps
module tb_lu_stall_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_instr;
    logic [7:0]  dec_ctrl;
    logic        dec_uses_rt;
    logic [31:0] pc_q, ifid_instr_q;
    logic [7:0]  idex_ctrl_q, exmem_ctrl_q, memwb_ctrl_q;
    logic [4:0]  idex_rt_q;
    logic        pc_write, ifid_write, idex_bubble;

    always #2.5 clk = ~clk;

    lu_stall_unit dut (
        .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .dec_ctrl(dec_ctrl),
        .dec_uses_rt(dec_uses_rt), .pc_q(pc_q), .ifid_instr_q(ifid_instr_q),
        .idex_ctrl_q(idex_ctrl_q), .idex_rt_q(idex_rt_q), .exmem_ctrl_q(exmem_ctrl_q),
        .memwb_ctrl_q(memwb_ctrl_q), .pc_write(pc_write), .ifid_write(ifid_write),
        .idex_bubble(idex_bubble)
    );

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    logic [31:0] prog [0:15];

    function automatic logic [31:0] mk(int rs, int rt, logic [7:0] c, bit u);
        return {6'h01, 5'(rs), 5'(rt), u, 7'h00, c};
    endfunction

    function automatic logic [31:0] imem(logic [31:0] a);
        return (a[31:2] < 16) ? prog[a[5:2]] : 32'h0;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference state
    logic [31:0] m_pc, m_ifid;
    logic [7:0]  m_ex, m_mem, m_wb;
    logic [4:0]  m_rt;

    initial begin
        prog[0]  = mk(1, 5, 8'h03, 0);   // load r5
        prog[1]  = mk(5, 2, 8'h02, 1);   // reads r5 in first field: stall (R1)
        prog[2]  = mk(1, 6, 8'h03, 0);   // load r6
        prog[3]  = mk(3, 6, 8'h12, 1);   // reads r6 in second field: stall (R8)
        prog[4]  = mk(1, 7, 8'h03, 0);   // load r7
        prog[5]  = mk(4, 7, 8'h22, 0);   // second field unused: no stall (R8)
        prog[6]  = mk(1, 0, 8'h03, 0);   // load r0
        prog[7]  = mk(0, 0, 8'h02, 1);   // no stall (R7)
        prog[8]  = mk(1, 8, 8'h02, 0);   // non-load writes r8
        prog[9]  = mk(8, 8, 8'h02, 1);   // no stall (R9)
        prog[10] = mk(1, 9, 8'h03, 0);   // load r9
        prog[11] = mk(2, 3, 8'h40, 1);   // independent
        prog[12] = mk(9, 9, 8'h02, 1);   // two apart: no stall
        prog[13] = mk(11, 10, 8'h03, 0); // load r10
        prog[14] = mk(10, 11, 8'h83, 0); // load r11 using r10: stall
        prog[15] = mk(2, 11, 8'h04, 1);  // store using r11: stall
    end

    initial begin
        bit  exp_stall, prev_stall;
        int  nstall;
        string tag;
        rst_n = 1'b0; fetch_instr = '0; dec_ctrl = '0; dec_uses_rt = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "pc", pc_q, 0);
        chk("R10", "ifid", ifid_instr_q, 0);
        chk("R10", "idex", {24'h0, idex_ctrl_q}, 0);
        chk("R10", "memwb", {24'h0, memwb_ctrl_q}, 0);
        chk("R10", "bubble", {31'h0, idex_bubble}, 0);
        rst_n = 1'b1;
        m_pc = 0; m_ifid = 0; m_ex = 0; m_mem = 0; m_wb = 0; m_rt = 0;
        prev_stall = 0; nstall = 0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            fetch_instr = imem(m_pc);
            dec_ctrl    = m_ifid[7:0];
            dec_uses_rt = m_ifid[15];
            #1;
            exp_stall = m_ex[0] && (m_rt != 0) &&
                        ((m_rt == m_ifid[25:21]) || (m_ifid[15] && (m_rt == m_ifid[20:16])));
            if (prev_stall)          tag = "R6";
            else if (!m_ex[0])       tag = "R9";
            else if (m_rt == 0)      tag = "R7";
            else if (m_rt == m_ifid[25:21]) tag = "R1";
            else                     tag = "R8";
            chk(tag, "bubble", {31'h0, idex_bubble}, {31'h0, exp_stall});
            chk("R2", "pc_write", {31'h0, pc_write}, {31'h0, !exp_stall});
            chk("R3", "ifid_write", {31'h0, ifid_write}, {31'h0, !exp_stall});
            chk("R2", "pc", pc_q, m_pc);
            chk("R3", "ifid", ifid_instr_q, m_ifid);
            chk("R4", "idex_ctrl", {24'h0, idex_ctrl_q}, {24'h0, m_ex});
            chk("R4", "idex_rt", {27'h0, idex_rt_q}, {27'h0, m_rt});
            chk("R5", "exmem", {24'h0, exmem_ctrl_q}, {24'h0, m_mem});
            chk("R5", "memwb", {24'h0, memwb_ctrl_q}, {24'h0, m_wb});
            if (exp_stall) nstall++;
            m_wb  = m_mem;
            m_mem = m_ex;
            m_ex  = exp_stall ? 8'h00 : m_ifid[7:0];
            m_rt  = m_ifid[20:16];
            if (!exp_stall) begin
                m_ifid = imem(m_pc);
                m_pc   = m_pc + 4;
            end
            prev_stall = exp_stall;
            @(negedge clk);
        end
        chk("R6", "stall count", nstall, 4);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule